// File: doc/BRIEF.md
# Three-Way Set-Associative Write-Back Byte Cache

This block is a small data cache between a processor that issues single-byte reads and writes and a memory that moves whole lines. It stores 24 bytes as two sets of three ways, each way holding a 4-byte line. A request is offered on a 10-bit byte address together with a read or write strobe. The block takes the request only in a cycle where it shows itself ready, so it latches everything it needs at that point.

A hit is served from the cache's own storage and does not touch memory. On a miss the block picks a victim way. An empty way is chosen first, and otherwise the least recently used way. If the victim holds modified data, the line is written back to memory. The missing line is then fetched and the request completes on it. Writes allocate on a miss and mark the line modified.

When the block returns to ready, it presents two results for the request it just finished: a flag that says whether the request hit, and, for a read, the byte that was read.

Top module: `sa_wb_cache`

## Requirements
- R1: A synchronous reset sets `ready`=1 and `did_contain`=0, empties every way and clears every modified mark, so the first access to any address afterwards misses and writes nothing back.
- R2: Address fields are byte offset = addr[1:0], set index = addr[2] and tag = addr[9:3]. Byte offset k occupies bits [8k+7:8k] of a line. The memory block address is addr[9:2].
- R3: A request is accepted only on a rising edge where `ready`=1 and `cpu_rd` or `cpu_wr` is 1. Address, strobe and write data are latched on that edge, and input changes after it have no effect. If both strobes are 1, the request is a write.
- R4: A read hit returns the stored byte with `did_contain`=1. It causes no memory transfer, and `ready` returns 2 cycles after acceptance.
- R5: A read miss with a clean or empty victim asserts `mem_rd` for exactly one cycle with `mem_addr` = addr[9:2]. It then returns to ready with `did_contain`=0 and the byte taken from `mem_line_in`, 3 cycles after acceptance.
- R6: A write hit replaces only the addressed byte, marks the line modified, reports `did_contain`=1 and causes no memory transfer.
- R7: A write miss fetches the line, merges the written byte into it, stores it as modified and reports `did_contain`=0.
- R8: A miss whose victim is valid and modified first asserts `mem_wr` for one cycle. In that cycle `mem_addr` = {victim tag, set index} and `mem_line_out` = the victim line. The fetch cycle follows, and `ready` returns 4 cycles after acceptance.
- R9: Evicting an unmodified line causes no memory write.
- R10: The victim is the lowest-numbered empty way of the set if one exists, otherwise the least recently used way. Each hit or fill makes its way the most recently used. Sets keep independent orders, and after reset way 0 is the oldest.
- R11: `mem_rd` and `mem_wr` are never 1 together. Every request finishes within 10 cycles of acceptance, and the worst case is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 10 | Byte address of the request |
| cpu_rd | input | 1 | Read strobe, sampled when ready |
| cpu_wr | input | 1 | Write strobe, sampled when ready |
| cpu_wdata | input | 8 | Byte to write |
| mem_line_in | input | 32 | Line returned by memory while `mem_rd` is 1 |
| ready | output | 1 | Idle; results of the last request are valid |
| did_contain | output | 1 | Last request hit |
| byte_read | output | 8 | Byte returned by the last read |
| mem_addr | output | 8 | Block address for the memory transfer |
| mem_rd | output | 1 | Line fetch request |
| mem_wr | output | 1 | Line write-back request |
| mem_line_out | output | 32 | Line written back to memory |

## Verification
Two functions meet on a dirty miss: the victim's write-back and the new line's fetch run back to back, and their addresses and data must not cross. The bench provokes this by filling a set until a line modified earlier becomes least recently used, and then asking for a new tag. The request is judged on the write-back block address and the cycle count. It is also judged on a later miss to the evicted address, which must return the modified byte from memory. Another collision is judged in the same way: a request that raises both strobes at once must act as a write.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W     = 10;
    localparam int BYTE_W     = 8;
    localparam int LINE_BYTES = 4;
    localparam int SETS       = 2;
    localparam int WAYS       = 3;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * BYTE_W;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [WAY_W-1:0]  way_t;

    typedef struct packed {
        addr_t addr;
        logic  is_wr;
        byte_t wdata;
    } req_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL
    } state_e;

    function automatic off_t addr_off(addr_t a);
        return a[OFF_W-1:0];
    endfunction

    function automatic idx_t addr_idx(addr_t a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic tag_t addr_tag(addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic byte_t get_byte(line_t l, off_t o);
        return l[int'(o)*BYTE_W +: BYTE_W];
    endfunction

    function automatic line_t put_byte(line_t l, off_t o, byte_t b);
        line_t r;
        r = l;
        r[int'(o)*BYTE_W +: BYTE_W] = b;
        return r;
    endfunction
endpackage

// File: rtl/cache_lru.sv
module cache_lru
    import cache_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic touch_en,
    input  idx_t touch_idx,
    input  way_t touch_way,
    input  idx_t query_idx,
    output way_t lru_way
);
    // age 0 = most recent, WAYS-1 = least recent
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(WAYS - 1 - w);
                end
            end else if (touch_en && touch_idx == idx_t'(s)) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (way_t'(w) == touch_way) begin
                        age_q[s][w] <= '0;
                    end else if (age_q[s][w] < age_q[s][touch_way]) begin
                        age_q[s][w] <= age_q[s][w] + 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[query_idx][w] == WAY_W'(WAYS - 1)) begin
                lru_way = way_t'(w);
            end
        end
    end
endmodule

// File: rtl/cache_store.sv
module cache_store
    import cache_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  idx_t                         rd_idx,
    output logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    output logic [WAYS-1:0][LINE_W-1:0]  way_line,
    output logic [WAYS-1:0]              way_valid,
    output logic [WAYS-1:0]              way_dirty,
    input  logic                         we,
    input  idx_t                         wr_idx,
    input  way_t                         wr_way,
    input  tag_t                         wr_tag,
    input  line_t                        wr_line,
    input  logic                         wr_dirty
);
    tag_t  tag_mem  [SETS][WAYS];
    line_t line_mem [SETS][WAYS];
    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [SETS-1:0][WAYS-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (we) begin
            valid_q[wr_idx][wr_way] <= 1'b1;
            dirty_q[wr_idx][wr_way] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_mem[wr_idx][wr_way]  <= wr_tag;
            line_mem[wr_idx][wr_way] <= wr_line;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign way_tag[w]   = tag_mem[rd_idx][w];
        assign way_line[w]  = line_mem[rd_idx][w];
        assign way_valid[w] = valid_q[rd_idx][w];
        assign way_dirty[w] = dirty_q[rd_idx][w];
    end
endmodule

// File: rtl/cache_way_sel.sv
module cache_way_sel
    import cache_pkg::*;
(
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  tag_t                       req_tag,
    input  way_t                       lru_way,
    output logic                       hit,
    output way_t                       hit_way,
    output way_t                       victim_way
);
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_valid[w] && way_tag[w] == req_tag) begin
                hit     = 1'b1;
                hit_way = way_t'(w);
            end
        end
    end

    // lowest empty way wins, else the oldest
    always_comb begin
        victim_way = lru_way;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                victim_way = way_t'(w);
            end
        end
    end
endmodule

// File: rtl/sa_wb_cache.sv
module sa_wb_cache
    import cache_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [7:0]  cpu_wdata,
    input  logic [31:0] mem_line_in,
    output logic        ready,
    output logic        did_contain,
    output logic [7:0]  byte_read,
    output logic [7:0]  mem_addr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [31:0] mem_line_out
);
    state_e state_q;
    req_t   req_q;
    way_t   vic_q;
    logic   hit_q;
    byte_t  byte_q;

    logic [WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [WAYS-1:0][LINE_W-1:0] way_line;
    logic [WAYS-1:0]             way_valid;
    logic [WAYS-1:0]             way_dirty;
    logic  hit;
    way_t  hit_way, victim_way, lru_way;
    logic  st_we, st_dirty, touch_en;
    way_t  st_way, touch_way;
    line_t st_line;

    idx_t req_idx;
    tag_t req_tag;
    off_t req_off;
    assign req_idx = addr_idx(req_q.addr);
    assign req_tag = addr_tag(req_q.addr);
    assign req_off = addr_off(req_q.addr);

    cache_store u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (req_idx),
        .way_tag   (way_tag),
        .way_line  (way_line),
        .way_valid (way_valid),
        .way_dirty (way_dirty),
        .we        (st_we),
        .wr_idx    (req_idx),
        .wr_way    (st_way),
        .wr_tag    (req_tag),
        .wr_line   (st_line),
        .wr_dirty  (st_dirty)
    );

    cache_lru u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_idx (req_idx),
        .touch_way (touch_way),
        .query_idx (req_idx),
        .lru_way   (lru_way)
    );

    cache_way_sel u_sel (
        .way_tag    (way_tag),
        .way_valid  (way_valid),
        .req_tag    (req_tag),
        .lru_way    (lru_way),
        .hit        (hit),
        .hit_way    (hit_way),
        .victim_way (victim_way)
    );

    // storage and recency updates
    always_comb begin
        st_we     = 1'b0;
        st_dirty  = 1'b0;
        st_way    = hit_way;
        st_line   = way_line[hit_way];
        touch_en  = 1'b0;
        touch_way = hit_way;
        unique case (state_q)
            ST_LOOKUP: begin
                if (hit) begin
                    touch_en = 1'b1;
                    if (req_q.is_wr) begin
                        st_we    = 1'b1;
                        st_dirty = 1'b1;
                        st_line  = put_byte(way_line[hit_way], req_off, req_q.wdata);
                    end
                end
            end
            ST_FILL: begin
                st_we     = 1'b1;
                st_way    = vic_q;
                st_dirty  = req_q.is_wr;
                st_line   = req_q.is_wr ? put_byte(mem_line_in, req_off, req_q.wdata)
                                        : mem_line_in;
                touch_en  = 1'b1;
                touch_way = vic_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            vic_q   <= '0;
            hit_q   <= 1'b0;
            byte_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_rd || cpu_wr) begin
                        req_q   <= '{addr: cpu_addr, is_wr: cpu_wr, wdata: cpu_wdata};
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    hit_q <= hit;
                    if (hit) begin
                        if (!req_q.is_wr) begin
                            byte_q <= get_byte(way_line[hit_way], req_off);
                        end
                        state_q <= ST_IDLE;
                    end else begin
                        vic_q   <= victim_way;
                        state_q <= (way_valid[victim_way] && way_dirty[victim_way])
                                   ? ST_EVICT : ST_FILL;
                    end
                end
                ST_EVICT: state_q <= ST_FILL;
                ST_FILL: begin
                    if (!req_q.is_wr) begin
                        byte_q <= get_byte(mem_line_in, req_off);
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ready        = (state_q == ST_IDLE);
    assign did_contain  = hit_q;
    assign byte_read    = byte_q;
    assign mem_rd       = (state_q == ST_FILL);
    assign mem_wr       = (state_q == ST_EVICT);
    assign mem_addr     = (state_q == ST_EVICT) ? {way_tag[vic_q], req_idx}
                                                : req_q.addr[ADDR_W-1:OFF_W];
    assign mem_line_out = way_line[vic_q];
endmodule

// File: rtl/sa_wb_cache_chk.sv
module sa_wb_cache_chk (
    input logic clk,
    input logic rst,
    input logic cpu_rd,
    input logic cpu_wr,
    input logic ready,
    input logic did_contain,
    input logic mem_rd,
    input logic mem_wr
);
    logic [3:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || ready) begin
            busy_cnt <= '0;
        end else if (busy_cnt != 4'hF) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (ready && !did_contain));

    p_accept_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (ready && (cpu_rd || cpu_wr)) |=> !ready);

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!mem_rd && !mem_wr));

    p_fill_ends_miss_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (ready && !did_contain));

    p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (mem_rd && !mem_wr));

    p_one_xfer_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_bounded_latency_r11: assert property (@(posedge clk) disable iff (rst)
        busy_cnt < 4'd9);
endmodule

bind sa_wb_cache sa_wb_cache_chk chk_i (.*);

// File: tb/sa_wb_cache_tb_top.sv
module sa_wb_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [31:0] mem_line_in;
    logic        ready, did_contain, mem_rd, mem_wr;
    logic [7:0]  byte_read, mem_addr;
    logic [31:0] mem_line_out;

    int checks = 0;
    int failures = 0;
    logic [31:0] mem [256];

    always #2 clk = ~clk;

    sa_wb_cache dut_i (.*);

    function automatic logic [7:0] mem_byte(logic [9:0] a);
        return 8'((a * 5 + 1) ^ (a >> 4));
    endfunction

    assign mem_line_in = mem_rd ? mem[mem_addr] : 32'hEEEE_EEEE;

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_line_out;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic       wr;
        logic [9:0] addr;
        logic [7:0] wdata;
        logic       hit;
        logic       from_mem;
        logic [7:0] byte_exp;
        logic [1:0] fills;
        logic [1:0] wbs;
        logic [7:0] wb_blk;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 10'h000, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd0, 8'h00}, // R5 cold miss
        '{1'b0, 10'h001, 8'h00, 1'b1, 1'b1, 8'h00, 2'd0, 2'd0, 8'h00}, // R4
        '{1'b1, 10'h008, 8'h11, 1'b0, 1'b0, 8'h00, 2'd1, 2'd0, 8'h00}, // R7
        '{1'b0, 10'h008, 8'h00, 1'b1, 1'b0, 8'h11, 2'd0, 2'd0, 8'h00}, // R7 merged
        '{1'b0, 10'h009, 8'h00, 1'b1, 1'b1, 8'h00, 2'd0, 2'd0, 8'h00}, // R7 rest of line
        '{1'b0, 10'h010, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd0, 8'h00}, // R10 third way
        '{1'b0, 10'h004, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd0, 8'h00}, // R10 other set
        '{1'b0, 10'h002, 8'h00, 1'b1, 1'b1, 8'h00, 2'd0, 2'd0, 8'h00}, // R10 refresh
        '{1'b0, 10'h018, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd1, 8'h02}, // R8 dirty victim
        '{1'b0, 10'h008, 8'h00, 1'b0, 1'b0, 8'h11, 2'd1, 2'd0, 8'h00}, // R8 data, R9
        '{1'b1, 10'h003, 8'h33, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 8'h00}, // R6
        '{1'b0, 10'h003, 8'h00, 1'b1, 1'b0, 8'h33, 2'd0, 2'd0, 8'h00}, // R6
        '{1'b0, 10'h020, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd0, 8'h00}, // R9
        '{1'b0, 10'h028, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd0, 8'h00}, // R9
        '{1'b0, 10'h030, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd1, 8'h00}, // R8
        '{1'b0, 10'h003, 8'h00, 1'b0, 1'b0, 8'h33, 2'd1, 2'd0, 8'h00}, // R8 data
        '{1'b1, 10'h00C, 8'h77, 1'b0, 1'b0, 8'h00, 2'd1, 2'd0, 8'h00}, // R7 set 1
        '{1'b0, 10'h00C, 8'h00, 1'b1, 1'b0, 8'h77, 2'd0, 2'd0, 8'h00}  // R7
    };

    task automatic run_req(input vec_t v, input bit both);
        int n = 0;
        int fills = 0;
        int wbs = 0;
        logic [7:0] wb_blk = '0;
        logic [7:0] exp_b;
        string btag;
        @(negedge clk);
        while (!ready && n < 20) begin @(negedge clk); n++; end
        cpu_addr  = v.addr;
        cpu_rd    = both | ~v.wr;
        cpu_wr    = v.wr;
        cpu_wdata = v.wdata;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            // R3: junk on the inputs while busy must be ignored
            cpu_addr  = ~v.addr;
            cpu_rd    = 1'b1;
            cpu_wr    = ~v.wr;
            cpu_wdata = 8'hEE;
            if (mem_rd) begin
                fills++;
                check(mem_addr == v.addr[9:2], "R2 fill address", mem_addr, v.addr[9:2]);
            end
            if (mem_wr) begin
                wbs++;
                wb_blk = mem_addr;
            end
        end while (!ready && n < 12);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        check(n == 2 + v.fills + v.wbs && n <= 10, "R11 latency", n, 2 + v.fills + v.wbs);
        check(did_contain == v.hit, "R10 hit flag", did_contain, v.hit);
        check(fills == v.fills, "R5 fill count", fills, v.fills);
        check(wbs == v.wbs, "R8/R9 write-back count", wbs, v.wbs);
        if (v.wbs != 0) check(wb_blk == v.wb_blk, "R8 write-back address", wb_blk, v.wb_blk);
        if (!v.wr) begin
            exp_b = v.from_mem ? mem_byte(v.addr) : v.byte_exp;
            btag = v.from_mem ? (v.hit ? "R4 read byte" : "R5 read byte")
                              : (v.hit ? "R6/R7 read byte" : "R8 read byte");
            check(byte_read == exp_b, btag, byte_read, exp_b);
        end
    endtask

    initial begin
        for (int b = 0; b < 256; b++) begin
            mem[b] = {mem_byte(10'(b*4+3)), mem_byte(10'(b*4+2)),
                      mem_byte(10'(b*4+1)), mem_byte(10'(b*4))};
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready after reset", ready, 1);
        check(did_contain == 1'b0, "R1 hit flag after reset", did_contain, 0);

        for (int i = 0; i < NVEC; i++) run_req(VEC[i], 1'b0);

        // R3: both strobes raised -> write 0x99 to 0x00D (hit in set 1)
        run_req('{1'b1, 10'h00D, 8'h99, 1'b1, 1'b0, 8'h00, 2'd0, 2'd0, 8'h00}, 1'b1);
        run_req('{1'b0, 10'h00D, 8'h00, 1'b1, 1'b0, 8'h99, 2'd0, 2'd0, 8'h00}, 1'b0);

        // R1: reset discards the dirty line, next access misses without write-back
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready after second reset", ready, 1);
        check(did_contain == 1'b0, "R1 hit flag cleared", did_contain, 0);
        run_req('{1'b0, 10'h00C, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd0, 8'h00}, 1'b0);
        // R10: after reset fills go to way 0,1,2 in turn, then way 0 is oldest
        run_req('{1'b0, 10'h004, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd0, 8'h00}, 1'b0);
        run_req('{1'b0, 10'h014, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd0, 8'h00}, 1'b0);
        run_req('{1'b0, 10'h01C, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd0, 8'h00}, 1'b0);
        run_req('{1'b0, 10'h00C, 8'h00, 1'b0, 1'b1, 8'h00, 2'd1, 2'd0, 8'h00}, 1'b0);
        run_req('{1'b0, 10'h014, 8'h00, 1'b1, 1'b1, 8'h00, 2'd0, 2'd0, 8'h00}, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule